// File: doc/BRIEF.md
# Sine-Fit Self-Test Sequencer

The block runs the digital half of a converter self-test. A one-bit stimulus drives a known sine into the converter, and the block works on the decimated output, taking one sample per sample strobe. It first finds the DC level of the response. It then tunes the starting amplitude of an external rotation engine until the engine's sine matches the response. Finally it sums the absolute fitting error over a full record and shifts the fitted amplitude and the error sum out on a single pin. Logarithms and ratio figures are worked out off-chip from those two numbers.

The rotation engine sits outside the block. The block sets its mode (sine or divide), its starting value and its angle, and reads its result on `ref_i`. In divide mode the engine returns the quotient of the starting value by the record length. In sine mode it returns a sine scaled by the starting value at the angle presented. The angle comes from an unsigned phase counter that is folded into a triangle, so no angle wrap logic is needed. The amplitude is updated by a sign-based step scaled down by a shift. The noise figure is a sum of magnitudes, so the block has no multiplier.

Top module: `sine_fit_bist`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `sig_valid_o` and `cordic_div_o` are all 0.
- R2: A one-cycle `start_i` while idle or done begins a run, and `busy_o` rises on the next cycle and stays high until readout ends. A `start_i` while `busy_o` is high has no effect on the run or its results.
- R3: The first stage adds `N_REC` (563) sign-extended samples in an accumulator that is 5 bits wider than a sample. It then raises `cordic_div_o` and presents the sum, clipped to the signed 16-bit range, on `cordic_x0_o`.
- R4: While `cordic_div_o` is high, the value on `ref_i` at the next sample is stored as the offset. The offset stays unchanged at all other times.
- R5: The angle is `f(p) - 256`, where `p` is a 10-bit phase and `f(p) = p` when `p < 512`, else `1023 - p`. The phase restarts at 0 when the amplitude stage begins and again when the error stage begins. It advances by 116 after each sample of those stages.
- R6: The amplitude stage loads X0 with 256 and then runs for `N_AMP` (282) samples. For each sample it forms `d = ref_i + offset - sample`, negates `d` when the angle is negative, and sets X0 to `X0 - floor(d/32)`, clipped to 16 signed bits.
- R7: The error stage clears the accumulator and adds `|ref_i + offset - sample|` for `N_REC` samples.
- R8: Readout lasts exactly 32 consecutive cycles with `sig_valid_o` high, one bit per cycle, MSB first. The first 16 bits are the final X0. The last 16 bits are the error sum, clipped to 32767.
- R9: After readout, `done_o` is high and `busy_o` is low until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a run when idle or done |
| strobe_i | input | 1 | One-cycle pulse marking a valid converter sample |
| sample_i | input | 16 | Decimated converter sample, signed |
| ref_i | input | 16 | Rotation engine result (sine or quotient), signed |
| cordic_div_o | output | 1 | Engine mode: 1 = divide, 0 = sine |
| cordic_x0_o | output | 16 | Engine starting value (X0), signed |
| cordic_angle_o | output | 10 | Engine angle, signed triangle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, signature shifted out |
| sig_bit_o | output | 1 | Serial signature bit |
| sig_valid_o | output | 1 | Qualifies `sig_bit_o` |

## Verification
The embedded properties check the following on every cycle:
- busy and done are never high together, and a rise of busy always follows a start;
- done holds until the next start, and the serial strobe appears only during a run;
- the engine's starting value is held steady through the divide request, and the offset changes only then;
- the phase steps by the fixed increment or restarts at zero.

The numerical results need the bench's scenarios. These are the clipped sum offered for division, the sign-based amplitude walk, the magnitude error sum and the exact signature bits. The bench computes them from its own model for several offsets, amplitudes and noise levels, including a case where the sum clips and one where a start arrives mid-run.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFS,
    ST_DIV,
    ST_AMP,
    ST_ERR,
    ST_SHX,
    ST_SHR,
    ST_DONE
  } bist_state_e;
endpackage

// File: rtl/bist_angle_gen.sv
module bist_angle_gen #(
  parameter int AW   = 10,
  parameter int STEP = 116
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 adv_i,
  output logic signed [AW-1:0] angle_o
);
  localparam int QTR = 2 ** (AW - 2);

  logic [AW-1:0] phase_q;
  logic [AW-2:0] fold_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else if (adv_i) phase_q <= phase_q + AW'(STEP);
  end

  // second half of the counter runs back down: triangle from a sawtooth
  assign fold_w  = phase_q[AW-1] ? ~phase_q[AW-2:0] : phase_q[AW-2:0];
  assign angle_o = $signed({1'b0, fold_w}) - $signed(AW'(QTR));

  a_r5_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (phase_q == $past(phase_q) + AW'(STEP)));
  a_r5_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/bist_fit_alu.sv
module bist_fit_alu #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] ref_i,
  input  logic signed [W-1:0] ofs_i,
  input  logic signed [W-1:0] smp_i,
  input  logic                neg_i,
  output logic signed [W+1:0] adj_o,
  output logic        [W+1:0] mag_o
);
  localparam int DW = W + 2;

  logic signed [DW-1:0] corr_w;
  logic signed [DW-1:0] diff_w;

  // three add/subtract units: offset correction, error, sign/magnitude
  assign corr_w = DW'(ref_i) + DW'(ofs_i);
  assign diff_w = corr_w - DW'(smp_i);
  assign adj_o  = neg_i ? -diff_w : diff_w;
  assign mag_o  = diff_w[DW-1] ? DW'(-diff_w) : DW'(diff_w);
endmodule

// File: rtl/sine_fit_bist.sv
module sine_fit_bist
  import bist_pkg::*;
#(
  parameter int W          = 16,
  parameter int AW         = 10,
  parameter int N_REC      = 563,
  parameter int N_AMP      = 282,
  parameter int PHASE_STEP = 116,
  parameter int X0_INIT    = 256,
  parameter int LR_SHIFT   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 strobe_i,
  input  logic signed [W-1:0]  sample_i,
  input  logic signed [W-1:0]  ref_i,
  output logic                 cordic_div_o,
  output logic signed [W-1:0]  cordic_x0_o,
  output logic signed [AW-1:0] cordic_angle_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sig_bit_o,
  output logic                 sig_valid_o
);
  localparam int ACC = W + 5;
  localparam int DW  = W + 2;
  localparam int CW  = $clog2(N_REC + 1);
  localparam int BW  = $clog2(W);
  localparam logic signed [ACC-1:0] SAT_HI = ACC'((2 ** (W - 1)) - 1);
  localparam logic signed [ACC-1:0] SAT_LO = -SAT_HI - ACC'(1);

  function automatic logic signed [W-1:0] clip_w(input logic signed [ACC-1:0] v);
    if (v > SAT_HI)      return SAT_HI[W-1:0];
    else if (v < SAT_LO) return SAT_LO[W-1:0];
    else                 return v[W-1:0];
  endfunction

  function automatic logic signed [ACC-1:0] sext_w(input logic signed [W-1:0] v);
    return {{(ACC-W){v[W-1]}}, v};
  endfunction

  bist_state_e state_q;
  logic [CW-1:0]         cnt_q;
  logic [BW-1:0]         bcnt_q;
  logic signed [ACC-1:0] acc_q;
  logic signed [W-1:0]   x0_q;
  logic signed [W-1:0]   ofs_q;
  logic signed [W-1:0]   smp_q;
  logic                  pend_q;

  // named internal events
  logic proc_w, active_w, rec_last_w, amp_last_w, bit_last_w, idle_w;
  logic ang_clr_w, ang_adv_w;
  logic signed [AW-1:0]  angle_w;
  logic signed [DW-1:0]  adj_w;
  logic        [DW-1:0]  mag_w;
  logic signed [ACC-1:0] ofs_sum_w, step_w, x0_upd_w, err_sum_w;

  assign active_w   = (state_q == ST_OFS) || (state_q == ST_DIV) ||
                      (state_q == ST_AMP) || (state_q == ST_ERR);
  assign idle_w     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign proc_w     = pend_q;
  assign rec_last_w = (cnt_q == CW'(N_REC - 1));
  assign amp_last_w = (cnt_q == CW'(N_AMP - 1));
  assign bit_last_w = (bcnt_q == BW'(W - 1));
  assign ang_clr_w  = proc_w && ((state_q == ST_DIV) || (state_q == ST_AMP && amp_last_w));
  assign ang_adv_w  = proc_w && ((state_q == ST_AMP) || (state_q == ST_ERR));

  bist_angle_gen #(.AW(AW), .STEP(PHASE_STEP)) u_angle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ang_clr_w),
    .adv_i  (ang_adv_w),
    .angle_o(angle_w)
  );

  bist_fit_alu #(.W(W)) u_alu (
    .ref_i(ref_i),
    .ofs_i(ofs_q),
    .smp_i(smp_q),
    .neg_i(angle_w[AW-1]),
    .adj_o(adj_w),
    .mag_o(mag_w)
  );

  assign ofs_sum_w = acc_q + sext_w(smp_q);
  assign step_w    = $signed({{(ACC-DW){adj_w[DW-1]}}, adj_w}) >>> LR_SHIFT;
  assign x0_upd_w  = sext_w(x0_q) - step_w;
  assign err_sum_w = acc_q + $signed({{(ACC-DW){1'b0}}, mag_w});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      smp_q  <= '0;
    end else begin
      pend_q <= strobe_i && active_w;
      if (strobe_i) smp_q <= sample_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bcnt_q  <= '0;
      acc_q   <= '0;
      x0_q    <= '0;
      ofs_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_OFS;
          cnt_q   <= '0;
          acc_q   <= '0;
        end
        ST_OFS: if (proc_w) begin
          acc_q <= ofs_sum_w;
          cnt_q <= cnt_q + CW'(1);
          if (rec_last_w) begin
            x0_q    <= clip_w(ofs_sum_w);
            cnt_q   <= '0;
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (proc_w) begin
          ofs_q   <= ref_i;
          x0_q    <= W'(X0_INIT);
          state_q <= ST_AMP;
        end
        ST_AMP: if (proc_w) begin
          x0_q  <= clip_w(x0_upd_w);
          cnt_q <= cnt_q + CW'(1);
          if (amp_last_w) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            state_q <= ST_ERR;
          end
        end
        ST_ERR: if (proc_w) begin
          acc_q <= err_sum_w;
          cnt_q <= cnt_q + CW'(1);
          if (rec_last_w) begin
            cnt_q   <= '0;
            bcnt_q  <= '0;
            state_q <= ST_SHX;
          end
        end
        ST_SHX: begin
          x0_q   <= x0_q <<< 1;
          bcnt_q <= bcnt_q + BW'(1);
          if (bit_last_w) begin
            x0_q    <= clip_w(acc_q);
            bcnt_q  <= '0;
            state_q <= ST_SHR;
          end
        end
        ST_SHR: begin
          x0_q   <= x0_q <<< 1;
          bcnt_q <= bcnt_q + BW'(1);
          if (bit_last_w) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cordic_div_o   = (state_q == ST_DIV);
  assign cordic_x0_o    = x0_q;
  assign cordic_angle_o = angle_w;
  assign busy_o         = !idle_w;
  assign done_o         = (state_q == ST_DONE);
  assign sig_valid_o    = (state_q == ST_SHX) || (state_q == ST_SHR);
  assign sig_bit_o      = sig_valid_o && x0_q[W-1];

  a_r2_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r2_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r8_valid_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_valid_o |-> busy_o);
  a_r9_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  a_r3_div_x0_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cordic_div_o && !proc_w) |=> $stable(cordic_x0_o));
  a_r4_offset_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cordic_div_o |=> $stable(ofs_q));
endmodule

// File: tb/sine_fit_bist_tb_top.sv
module sine_fit_bist_tb_top;
  localparam int N_REC = 563;
  localparam int N_AMP = 282;
  localparam int STEP  = 116;
  localparam int NSC   = 4;
  localparam int SC_OFF [NSC] = '{-20, 37, 100, 5};
  localparam int SC_AMP [NSC] = '{300, 200, 400, 256};
  localparam int SC_NZ  [NSC] = '{2, 5, 1, 200};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, strobe = 1'b0;
  logic signed [15:0] sample = '0, refv = '0;
  logic div_o, busy, done, sbit, svalid;
  logic signed [15:0] x0_o;
  logic signed [9:0]  angle;

  int checks = 0, fails = 0;
  int vcnt = 0;
  logic [31:0] sig_sr = '0;

  always #5 clk = ~clk;

  sine_fit_bist dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .strobe_i(strobe),
    .sample_i(sample), .ref_i(refv), .cordic_div_o(div_o), .cordic_x0_o(x0_o),
    .cordic_angle_o(angle), .busy_o(busy), .done_o(done),
    .sig_bit_o(sbit), .sig_valid_o(svalid)
  );

  always @(negedge clk) if (svalid) begin
    sig_sr <= {sig_sr[30:0], sbit};
    vcnt   <= vcnt + 1;
  end

  function automatic int fdiv(int v, int d);
    if (v >= 0) return v / d;
    return -((-v + d - 1) / d);
  endfunction
  function automatic int clip16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic int tri_ang(int p);
    return ((p < 512) ? p : (1023 - p)) - 256;
  endfunction
  function automatic int nz(int k, int n);
    return ((k * 7) % (2 * n + 1)) - n;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobe_one(int s, int r, bit st);
    sample = 16'(s);
    refv   = 16'(r);
    strobe = 1'b1;
    start  = st;
    @(negedge clk);
    strobe = 1'b0;
    start  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_scenario(int sc);
    int off = SC_OFF[sc];
    int amp = SC_AMP[sc];
    int nl  = SC_NZ[sc];
    int sum = 0, ofsm, x0m, noise = 0, a, r, s, d;
    vcnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    // offset stage; scenario 1 pulses start mid-run (must be ignored)
    for (int k = 0; k < N_REC; k++) begin
      a = tri_ang((k * STEP) % 1024);
      s = off + fdiv(amp * a, 256) + nz(k, nl);
      sum += s;
      strobe_one(s, 0, (sc == 1) && (k == 100));
    end
    if (sc == 1) check(busy === 1'b1, "R2", "busy after ignored start", int'(busy), 1);
    check(div_o === 1'b1, "R3", "divide mode", int'(div_o), 1);
    check(int'(x0_o) == clip16(sum), "R3", "clipped sum on x0", int'(x0_o), clip16(sum));
    ofsm = clip16(sum) / N_REC;
    strobe_one(0, ofsm, 1'b0);
    // amplitude stage
    x0m = 256;
    for (int j = 0; j < N_AMP; j++) begin
      a = tri_ang((j * STEP) % 1024);
      if (j == 0 || j == 5)
        check(int'(angle) == a, "R5", "amp-stage angle", int'(angle), a);
      r = fdiv(x0m * a, 256);
      s = off + fdiv(amp * a, 256) + nz(j + 3, nl);
      d = r + ofsm - s;
      if (a < 0) d = -d;
      x0m = clip16(x0m - fdiv(d, 32));
      strobe_one(s, r, 1'b0);
    end
    // error stage
    for (int j = 0; j < N_REC; j++) begin
      a = tri_ang((j * STEP) % 1024);
      if (j == 0 || j == 9)
        check(int'(angle) == a, "R5", "err-stage angle", int'(angle), a);
      r = fdiv(x0m * a, 256);
      s = off + fdiv(amp * a, 256) + nz(j + 11, nl);
      d = r + ofsm - s;
      noise += (d < 0) ? -d : d;
      strobe_one(s, r, 1'b0);
    end
    for (int w = 0; w < 100 && !done; w++) @(negedge clk);
    check(vcnt == 32, "R8", "valid cycles", vcnt, 32);
    check(int'($signed(sig_sr[31:16])) == x0m, "R6", "signature X0",
          int'($signed(sig_sr[31:16])), x0m);
    check(int'(sig_sr[15:0]) == clip16(noise), "R4,R7", "signature error sum",
          int'(sig_sr[15:0]), clip16(noise));
    check(done === 1'b1 && busy === 1'b0, "R9", "done after readout",
          int'({done, busy}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done at reset", int'({busy, done}), 0);
    check(svalid === 1'b0 && div_o === 1'b0, "R1", "valid/div at reset", int'({svalid, div_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R1", "idle after reset release", int'(busy), 0);
    for (int sc = 0; sc < NSC; sc++) begin
      run_scenario(sc);
      repeat (5) @(negedge clk);
      check(done === 1'b1, "R9", "done held while waiting", int'(done), 1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule